// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block sits on a two-wire serial bus as a target and serves a small, byte-wide, nonvolatile-style memory modelled as a register array. The bus host addresses it with a control byte whose upper nibble is a fixed device code. The control byte's lowest bit picks the direction: 0 writes and 1 reads. The three bits between the nibble and the direction bit are not decoded. A write transfer carries one word address and then one or more data bytes. A read transfer returns bytes from a single internal pointer. Every byte access, read or write, moves that pointer, so reads and writes can be chained without re-addressing.

Both bus lines pass through a synchronizer clocked by the system clock. The block finds start and stop conditions and clock edges in that sampled domain. It drives the data line only by pulling it low, through an output enable, so the line stays open-drain. Write data collects in a page buffer and reaches the array in one cycle when a stop arrives. A low-voltage inhibit input stops that commit, so a supply dip cannot corrupt stored bytes.

A random read is a write transfer that carries only the word address, followed by a repeated start and a read control byte. The dummy write loads the pointer and then ends without storing anything.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A control byte whose bits [7:4] equal 4'b1010 is acknowledged whatever its bits [3:1] hold. Any other value in bits [7:4] gets no acknowledge, and every later byte up to the next start is ignored and also left unacknowledged.
- R2: In a write transfer, the byte after the control byte is the word address and is acknowledged. Its bits [6:0] load the 7-bit pointer and its bit 7 is ignored.
- R3: A write transfer with one data byte followed by a stop stores that byte at the pointer address. Every data byte is acknowledged.
- R4: In a page write, each data byte goes to the page slot named by the pointer's bits [2:0]. Those bits then step and wrap within the 8-byte page while bits [6:3] stay fixed, so the ninth and later bytes overwrite earlier slots.
- R5: Buffered write data reaches the array only on a stop that follows at least one data byte. A repeated start that cuts off a write transfer stores nothing.
- R6: If the low-voltage inhibit input is high when the stop arrives, the array is left unchanged.
- R7: A read control byte that comes with no word address returns the byte at the address after the previous access, whether that access was a read or a write.
- R8: A dummy write of a word address, then a repeated start and a read control byte, returns the byte at that address.
- R9: After each byte the target sends, a host acknowledge (data line low in the ninth clock) makes it send the byte at the next address. The address wraps from 127 to 0.
- R10: After a host non-acknowledge, and whenever the bus is idle or the block is in reset, the target does not drive the data line.
- R11: The target sends data bits MSB first. It pulls the data line low during the ninth clock of every byte it accepts, and it changes its drive only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to sample both bus lines |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaOe | output | 1 | Open-drain pull-down enable for the data line (1 pulls low) |
| lowVoltInhibit | input | 1 | High while the supply is too low for array writes |

## Verification
A stop condition can both commit the page buffer and meet an asserted low-voltage inhibit in the same cycle. The bench provokes this by raising the inhibit before it sends the stop of a complete write transfer, with the transfer itself acknowledged normally. It judges the outcome by reading the address back after the inhibit drops and expecting the old content. A start condition can also land while page data is buffered. The bench sends a data byte, issues a repeated start instead of a stop, and reads the address back through that same repeated start to confirm that nothing was stored.

// File: rtl/eeprom_pkg.sv
package eepromPkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_IGNORE
  } busState_t;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftIn;   // capture one received bit
    logic loadPtr;   // received byte becomes the pointer
    logic bufWrite;  // received byte goes to the page buffer
    logic loadTx;    // fetch array byte at pointer for sending
    logic shiftTx;   // present next transmit bit
    logic incPtr;    // read byte finished, advance pointer
    logic commit;    // copy buffered page bytes into array
    logic clearBuf;  // drop buffered page bytes
  } dpStrobes_t;

endpackage

// File: rtl/eeprom_bus_sync.sv
module eeprom_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;

  generate
    if (SYNC_STAGES == 1) begin : gSingle
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe[0] <= sclIn;
          sdaPipe[0] <= sdaIn;
        end
      end
    end else begin : gChain
      always_ff @(posedge clk) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign sclRise  = sclS & ~sclPrev;
  assign sclFall  = ~sclS & sclPrev;
  assign startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;

endmodule

// File: rtl/eeprom_ctrl.sv
module eeprom_ctrl
  import eepromPkg::*;
#(
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclRise,
  input  logic              sclFall,
  input  logic              startDet,
  input  logic              stopDet,
  input  logic              sdaS,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              txBit,
  input  logic              bufPending,
  input  logic              lowVoltInhibit,
  output dpStrobes_t        strobes,
  output logic              sdaOe,
  output busState_t         state
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(BYTE_W);

  logic [CNT_W-1:0] bitCnt;
  busState_t afterAck;
  logic hostAck;
  logic byteDone;

  assign byteDone = sclFall && (bitCnt == BIT_LAST);

  always_comb begin
    strobes = '0;
    if (startDet) begin
      strobes.clearBuf = 1'b1;
    end else if (stopDet) begin
      strobes.clearBuf = 1'b1;
      strobes.commit   = bufPending && !lowVoltInhibit;
    end else begin
      case (state)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          strobes.shiftIn  = sclRise && (bitCnt != BIT_LAST);
          strobes.loadPtr  = byteDone && (state == ST_ADDR);
          strobes.bufWrite = byteDone && (state == ST_WDATA);
        end
        ST_ACK:   strobes.loadTx = sclFall && (afterAck == ST_RDATA);
        ST_RDATA: begin
          strobes.incPtr  = byteDone;
          strobes.shiftTx = sclFall && (bitCnt != BIT_LAST);
        end
        ST_RACK:  strobes.loadTx = sclFall && hostAck;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      afterAck <= ST_IDLE;
      bitCnt   <= '0;
      hostAck  <= 1'b0;
    end else if (startDet) begin
      state  <= ST_CTRL;
      bitCnt <= '0;
    end else if (stopDet) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (sclRise && bitCnt != BIT_LAST) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (byteDone) begin
            bitCnt <= '0;
            state  <= ST_ACK;
            if (state == ST_CTRL) begin
              if (rxByte[BYTE_W-1 -: 4] != DEV_CODE) begin
                state <= ST_IGNORE;
              end else begin
                afterAck <= rxByte[0] ? ST_RDATA : ST_ADDR;
              end
            end else begin
              afterAck <= ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (sclFall) begin
            state  <= afterAck;
            bitCnt <= '0;
          end
        end
        ST_RDATA: begin
          if (sclRise && bitCnt != BIT_LAST) begin
            bitCnt <= bitCnt + 1'b1;
          end else if (byteDone) begin
            state <= ST_RACK;
          end
        end
        ST_RACK: begin
          if (sclRise) begin
            hostAck <= !sdaS;
          end else if (sclFall) begin
            bitCnt <= '0;
            state  <= hostAck ? ST_RDATA : ST_IGNORE;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (state)
      ST_ACK:   sdaOe = 1'b1;
      ST_RDATA: sdaOe = !txBit;
      default:  sdaOe = 1'b0;
    endcase
  end

endmodule

// File: rtl/eeprom_datapath.sv
module eeprom_datapath
  import eepromPkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic              sdaS,
  output logic [BYTE_W-1:0] rxByte,
  output logic              txBit,
  output logic              bufPending,
  output logic              arrayWe
);

  localparam int DEPTH      = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int BASE_W     = ADDR_W - PAGE_W;

  logic [BYTE_W-1:0] memArray [DEPTH];
  logic [BYTE_W-1:0] pageBuf  [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] pageValid;
  logic [ADDR_W-1:0] ptr;
  logic [BYTE_W-1:0] rxShift;
  logic [BYTE_W-1:0] txShift;

  assign rxByte     = rxShift;
  assign txBit      = txShift[BYTE_W-1];
  assign bufPending = |pageValid;
  assign arrayWe    = strobes.commit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxShift <= '0;
      txShift <= '1;
    end else begin
      if (strobes.shiftIn) rxShift <= {rxShift[BYTE_W-2:0], sdaS};
      if (strobes.loadTx)       txShift <= memArray[ptr];
      else if (strobes.shiftTx) txShift <= {txShift[BYTE_W-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobes.loadPtr) begin
      ptr <= rxShift[ADDR_W-1:0];
    end else if (strobes.incPtr) begin
      ptr <= ptr + 1'b1;
    end else if (strobes.bufWrite) begin
      ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageValid <= '0;
      for (int i = 0; i < PAGE_BYTES; i++) pageBuf[i] <= '0;
    end else if (strobes.clearBuf) begin
      pageValid <= '0;
    end else if (strobes.bufWrite) begin
      pageBuf[ptr[PAGE_W-1:0]]   <= rxShift;
      pageValid[ptr[PAGE_W-1:0]] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int a = 0; a < DEPTH; a++) memArray[a] <= '0;
    end else if (strobes.commit) begin
      for (int i = 0; i < PAGE_BYTES; i++) begin
        if (pageValid[i]) begin
          memArray[{ptr[ADDR_W-1 -: BASE_W], PAGE_W'(i)}] <= pageBuf[i];
        end
      end
    end
  end

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
  import eepromPkg::*;
#(
  parameter int         ADDR_W      = 7,
  parameter int         PAGE_W      = 3,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaOe,
  input  logic lowVoltInhibit
);

  logic sclSync, sdaSync, sclRise, sclFall, startDet, stopDet;
  logic [BYTE_W-1:0] rxByte;
  logic txBit, bufPending, arrayWe;
  dpStrobes_t strobes;
  busState_t busState;

  eeprom_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclSync), .sdaS(sdaSync), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  eeprom_ctrl #(.DEV_CODE(DEV_CODE)) uCtrl (
    .clk(clk), .rstN(rstN), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet), .sdaS(sdaSync),
    .rxByte(rxByte), .txBit(txBit), .bufPending(bufPending),
    .lowVoltInhibit(lowVoltInhibit), .strobes(strobes), .sdaOe(sdaOe),
    .state(busState)
  );

  eeprom_datapath #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uDp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdaS(sdaSync),
    .rxByte(rxByte), .txBit(txBit), .bufPending(bufPending),
    .arrayWe(arrayWe)
  );

endmodule

// File: rtl/eeprom_i2c_checker.sv
module eeprom_i2c_checker
  import eepromPkg::*;
(
  input logic      clk,
  input logic      rstN,
  input logic      sclS,
  input logic      sdaOe,
  input logic      lowVoltInhibit,
  input logic      arrayWe,
  input logic      startDet,
  input logic      stopDet,
  input busState_t busState
);

  // R6: no array write while supply is low
  a_r6_no_write_inhibited: assert property (@(posedge clk) disable iff (!rstN)
    arrayWe |-> !lowVoltInhibit);

  // R5: array is written only in the stop cycle
  a_r5_commit_on_stop: assert property (@(posedge clk) disable iff (!rstN)
    arrayWe |-> stopDet);

  // R5: a start always restarts control-byte reception
  a_r5_start_restarts: assert property (@(posedge clk) disable iff (!rstN)
    startDet |=> busState == ST_CTRL);

  // R10: a stop returns the target to idle
  a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> busState == ST_IDLE);

  // R10: idle target leaves the data line alone
  a_r10_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    busState == ST_IDLE |-> !sdaOe);

  // R1: ignoring the bus means never driving it
  a_r1_ignore_silent: assert property (@(posedge clk) disable iff (!rstN)
    busState == ST_IGNORE |-> !sdaOe);

  // R11: drive changes only while the clock is low
  a_r11_stable_clock_high: assert property (@(posedge clk) disable iff (!rstN)
    (sclS && $past(sclS)) |-> $stable(sdaOe));

endmodule

bind eeprom_i2c_target eeprom_i2c_checker uChk (
  .clk(clk), .rstN(rstN), .sclS(sclSync), .sdaOe(sdaOe),
  .lowVoltInhibit(lowVoltInhibit), .arrayWe(arrayWe),
  .startDet(startDet), .stopDet(stopDet), .busState(busState)
);

// File: tb/eeprom_i2c_target_test.sv
`timescale 1ns/1ps
module eeprom_i2c_target_test;

  localparam int Q = 6;  // system clocks per quarter bus bit
  localparam logic [7:0] VADDR [8] = '{8'h03, 8'h10, 8'h1F, 8'h30, 8'h44, 8'h5A, 8'h66, 8'h7E};
  localparam logic [7:0] VDATA [8] = '{8'hA5, 8'h3C, 8'hF0, 8'h0F, 8'h81, 8'h7E, 8'hC3, 8'h19};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostScl = 1'b1;
  logic hostSda = 1'b1;
  logic lowVoltInhibit = 1'b0;
  logic sdaOe;
  logic sdaLine;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign sdaLine = hostSda & ~sdaOe;

  eeprom_i2c_target uut (
    .clk(clk), .rstN(rstN), .sclIn(hostScl), .sdaIn(sdaLine),
    .sdaOe(sdaOe), .lowVoltInhibit(lowVoltInhibit)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic busStart();
    hostScl = 1'b0; qwait();
    hostSda = 1'b1; qwait();
    hostScl = 1'b1; qwait();
    hostSda = 1'b0; qwait();
  endtask

  task automatic busStop();
    hostScl = 1'b0; qwait();
    hostSda = 1'b0; qwait();
    hostScl = 1'b1; qwait();
    hostSda = 1'b1; qwait();
    repeat (4) qwait();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      hostScl = 1'b0; qwait();
      hostSda = b[i]; qwait();
      hostScl = 1'b1; qwait(); qwait();
    end
    hostScl = 1'b0; qwait();
    hostSda = 1'b1; qwait();
    hostScl = 1'b1; qwait();
    acked = !sdaLine; qwait();
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      hostScl = 1'b0; qwait();
      hostSda = 1'b1; qwait();
      hostScl = 1'b1; qwait();
      b[i] = sdaLine; qwait();
    end
    hostScl = 1'b0; qwait();
    hostSda = !giveAck; qwait();
    hostScl = 1'b1; qwait(); qwait();
  endtask

  task automatic sendChk(input string tag, input logic [7:0] b, input logic expAck);
    logic a;
    sendByte(b, a);
    chk(tag, {7'd0, a}, {7'd0, expAck});
  endtask

  // write transfer of n bytes starting at data value first, step 1
  task automatic writeBytes(input logic [7:0] ctl, input logic [7:0] addr,
                            input logic [7:0] first, input int n, input string tag);
    busStart();
    sendChk({tag, " ctrl ack"}, ctl, 1'b1);
    sendChk({tag, " addr ack"}, addr, 1'b1);
    for (int k = 0; k < n; k++) sendChk({tag, " data ack"}, first + 8'(k), 1'b1);
    busStop();
  endtask

  task automatic randomRead(input logic [7:0] addr, output logic [7:0] b);
    busStart();
    sendChk("R8 dummy ctrl ack", 8'hA0, 1'b1);
    sendChk("R8 dummy addr ack", addr, 1'b1);
    busStart();
    sendChk("R8 read ctrl ack", 8'hA1, 1'b1);
    readByte(1'b0, b);
    busStop();
  endtask

  task automatic currentRead(output logic [7:0] b);
    busStart();
    sendChk("R7 read ctrl ack", 8'hA1, 1'b1);
    readByte(1'b0, b);
    busStop();
  endtask

  initial begin
    logic [7:0] rd;
    repeat (5) @(negedge clk);
    chk("R10 reset release", {7'd0, sdaOe}, 8'h00);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 idle release", {7'd0, sdaOe}, 8'h00);

    // vector table: single-byte write, random read back
    for (int v = 0; v < 8; v++) begin
      writeBytes(8'hA0, VADDR[v], VDATA[v], 1, "R3");
      randomRead(VADDR[v], rd);
      chk("R3 R8 R11 readback", rd, VDATA[v]);
    end

    // R7 after a read: read 0x2F then current read gives 0x30
    randomRead(8'h2F, rd);
    chk("R7 prior read", rd, 8'h00);
    currentRead(rd);
    chk("R7 after read", rd, 8'h0F);
    // R7 after a write: write 0x43 then current read gives 0x44
    writeBytes(8'hA0, 8'h43, 8'h5E, 1, "R7");
    currentRead(rd);
    chk("R7 after write", rd, 8'h81);

    // R1 wrong device code, later bytes ignored
    busStart();
    sendChk("R1 bad code nack", 8'hB0, 1'b0);
    sendChk("R1 ignored byte nack", 8'h12, 1'b0);
    chk("R1 no drive", {7'd0, sdaOe}, 8'h00);
    busStop();

    // R2 address bit 7 ignored, chip-select bits not decoded
    writeBytes(8'hAE, 8'h8A, 8'h3A, 1, "R2");
    randomRead(8'h0A, rd);
    chk("R2 msb ignored", rd, 8'h3A);

    // R4 page write of 10 bytes at 0x25 wraps in page 0x20
    writeBytes(8'hA0, 8'h25, 8'h60, 10, "R4");
    busStart();
    sendChk("R9 dummy ctrl", 8'hA0, 1'b1);
    sendChk("R9 dummy addr", 8'h20, 1'b1);
    busStart();
    sendChk("R9 read ctrl", 8'hA1, 1'b1);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] e;
      e = (k < 5) ? 8'h63 + 8'(k) : (k == 5) ? 8'h68 : (k == 6) ? 8'h69 : 8'h62;
      readByte(k != 7, rd);
      chk("R4 R9 page wrap seq read", rd, e);
    end
    busStop();
    chk("R10 released after nack", {7'd0, sdaOe}, 8'h00);

    // R9 sequential read wraps 127 -> 0
    writeBytes(8'hA0, 8'h7F, 8'hE7, 1, "R9");
    writeBytes(8'hA0, 8'h00, 8'h4B, 1, "R9");
    busStart();
    sendChk("R9 dummy ctrl", 8'hA0, 1'b1);
    sendChk("R9 dummy addr", 8'h7E, 1'b1);
    busStart();
    sendChk("R9 read ctrl", 8'hA1, 1'b1);
    readByte(1'b1, rd); chk("R9 byte 7E", rd, 8'h19);
    readByte(1'b1, rd); chk("R9 byte 7F", rd, 8'hE7);
    readByte(1'b0, rd); chk("R9 wrap to 00", rd, 8'h4B);
    busStop();

    // R6 inhibit at stop
    lowVoltInhibit = 1'b1;
    writeBytes(8'hA0, 8'h50, 8'hAA, 1, "R6");
    lowVoltInhibit = 1'b0;
    randomRead(8'h50, rd);
    chk("R6 inhibited write", rd, 8'h00);

    // R5 data byte then repeated start, no stop
    busStart();
    sendChk("R5 ctrl ack", 8'hA0, 1'b1);
    sendChk("R5 addr ack", 8'h60, 1'b1);
    sendChk("R5 data ack", 8'hBB, 1'b1);
    randomRead(8'h60, rd);
    chk("R5 aborted write", rd, 8'h00);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R10 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule